// File: doc/BRIEF.md
# Memory Port Traffic Exerciser

The exerciser drives a simple single-word memory command port on its own. It presents an address, a write word, a direction select and a request level. It then watches the port's returned read word and the port's ready flag, which stays high once a transfer is done. A single free-running counter sets the pace for the whole block. Its top bit chooses the direction, the next bits choose an entry in a small fixed table, and the low bits give the phase inside one transaction slot. The request is held as a long level window, so a port that is slow or has a long latency still has time to finish the transfer.

Over one counter period, the block writes every table entry and then reads every entry back. It compares each returned word with the table value. It keeps a saturating error count, a sticky fail flag and a pass flag. Designers use it to bring up a memory path, such as a bus master bridge in front of external RAM, with no processor in the system.

Top module: `mem_exerciser`

## Requirements
- R1: The counter resets to zero and counts up by one each clock. With the default widths it repeats every 2048 cycles. Bit 10 selects the direction (0 means write and drives `mem_wr_o` high; 1 means read and drives it low). Bits 9:8 give the table index, and bits 7:0 give the slot phase.
- R2: `mem_req_o` is registered. It goes high on the clock after the phase equals 20 and goes low on the clock after the phase equals 118. So it is high exactly while the counter's phase is between 21 and 118, inclusive.
- R3: Table indices 0, 1, 2 and 3 drive both `mem_addr_o` and `mem_wdata_o` to 20, 120, 30 and 10. Any index beyond the table gives the value 111. The two outputs stay unchanged for the whole of a slot.
- R4: In a read window, the first cycle with `mem_ready_i` high compares `mem_rdata_i` against the table value for the current index. A mismatch adds one to the error count on the next clock.
- R5: Only one comparison is made per read window. Changes to `mem_rdata_i` after the first ready cycle of a window have no effect on the error count.
- R6: A read window whose closing cycle (phase 118) passes with no ready seen counts one timeout error. If ready first appears in the closing cycle itself, the cycle counts as a normal comparison and not as a timeout.
- R7: `mem_ready_i` and `mem_rdata_i` are ignored during write windows. A write that never completes adds no error.
- R8: The error count saturates at its all-ones value (ERR_W bits, 8 by default).
- R9: `fail_o` goes high with the first error and stays high. `pass_o` is updated on the last cycle of each counter period: it goes high if the error count is zero and low otherwise.
- R10: A synchronous active-high `rst` clears the counter, the request, the error count, `fail_o` and `pass_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr_o | output | ADDR_W | Address of the current slot |
| mem_wdata_o | output | DATA_W | Word written in write slots |
| mem_wr_o | output | 1 | 1 = write, 0 = read |
| mem_req_o | output | 1 | Request level window |
| mem_rdata_i | input | DATA_W | Word returned by the port |
| mem_ready_i | input | 1 | Latched completion flag, held until the request drops |
| err_cnt_o | output | ERR_W | Saturating error count |
| fail_o | output | 1 | Sticky failure flag |
| pass_o | output | 1 | Clean-period flag |

## Verification
The first collision is between a late reply and the timeout. If the ready flag first appears in the same cycle that a read window closes, both the comparison and the timeout could claim that cycle. The bench sets its responder latency to 97 cycles, which lands ready exactly on phase 118, and expects no error. It then sets the latency to 98 cycles and expects exactly one timeout for each read window. The second collision is between a new error and saturation. The bench uses a 4-bit count and drives it past its maximum with timeouts and corrupt data, and it checks that the count stops at 15 while the fail flag stays high.

// File: rtl/mx_pkg.sv
package mx_pkg;

    // Number of populated pattern entries.
    localparam int unsigned TBL_N = 4;

    // Value used for any index outside the populated table.
    localparam logic [31:0] TBL_FALLBACK = 32'd111;

    // Pattern word for one table entry; address and write data share it.
    function automatic logic [31:0] tbl_word(input int unsigned i);
        logic [31:0] w;
        case (i)
            0:       w = 32'd20;
            1:       w = 32'd120;
            2:       w = 32'd30;
            3:       w = 32'd10;
            default: w = TBL_FALLBACK;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/mx_timebase.sv
module mx_timebase #(
    parameter int unsigned PH_W   = 8,
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned REQ_ON  = 20,
    parameter int unsigned REQ_OFF = 118
) (
    input  logic             clk,
    input  logic             rst,
    output logic             rd_sel,
    output logic [IDX_W-1:0] idx,
    output logic             req,
    output logic             win_close,
    output logic             period_end
);
    localparam int unsigned CNT_W = 1 + IDX_W + PH_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } tb_state_t;

    tb_state_t st_q, st_d;
    logic [PH_W-1:0] phase;

    assign phase = st_q.cnt[PH_W-1:0];

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        if (phase == PH_W'(REQ_ON))
            st_d.req = 1'b1;
        else if (phase == PH_W'(REQ_OFF))
            st_d.req = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rd_sel     = st_q.cnt[CNT_W-1];
    assign idx        = st_q.cnt[PH_W +: IDX_W];
    assign req        = st_q.req;
    assign win_close  = st_q.req && (phase == PH_W'(REQ_OFF));
    assign period_end = &st_q.cnt;

    // R2: window opens only after the opening phase
    p_req_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.req) |-> ($past(phase) == PH_W'(REQ_ON)));

    // R2: window closes only after the closing phase
    p_req_fall_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.req) |-> ($past(phase) == PH_W'(REQ_OFF)));

    // R1: direction and index hold during an open window
    p_slot_stable_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q.req && $past(st_q.req)) |-> ($stable(idx) && $stable(rd_sel)));

endmodule

// File: rtl/mx_pattern.sv
module mx_pattern #(
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] expect_word
);
    import mx_pkg::*;

    localparam int unsigned SLOTS = 1 << IDX_W;

    logic [31:0] tbl [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_tbl
        if (g < TBL_N) begin : g_fill
            assign tbl[g] = tbl_word(g);
        end else begin : g_pad
            assign tbl[g] = TBL_FALLBACK;
        end
    end

    assign addr        = ADDR_W'(tbl[idx]);
    assign wdata       = DATA_W'(tbl[idx]);
    assign expect_word = DATA_W'(tbl[idx]);

endmodule

// File: rtl/mx_scoreboard.sv
module mx_scoreboard #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ERR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              rd_sel,
    input  logic              win_close,
    input  logic              period_end,
    input  logic              ready,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] expect_word,
    output logic [ERR_W-1:0]  err_cnt,
    output logic              fail,
    output logic              pass
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    typedef struct packed {
        logic             done;
        logic [ERR_W-1:0] err;
        logic             fail;
        logic             pass;
    } sb_state_t;

    sb_state_t sb_q, sb_d;
    logic rd_win, sample, timeout, bump;

    always_comb begin
        sb_d    = sb_q;
        rd_win  = req && rd_sel;
        sample  = rd_win && ready && !sb_q.done;
        timeout = rd_win && win_close && !sb_q.done && !ready;
        bump    = timeout || (sample && (rdata != expect_word));

        if (sample)
            sb_d.done = 1'b1;
        if (!req)
            sb_d.done = 1'b0;

        if (bump) begin
            sb_d.fail = 1'b1;
            if (sb_q.err != ERR_MAX)
                sb_d.err = sb_q.err + 1'b1;
        end

        if (period_end)
            sb_d.pass = (sb_d.err == '0) && !sb_d.fail;
        else
            sb_d.pass = sb_q.pass && !sb_d.fail;
    end

    always_ff @(posedge clk) begin
        if (rst) sb_q <= '0;
        else     sb_q <= sb_d;
    end

    assign err_cnt = sb_q.err;
    assign fail    = sb_q.fail;
    assign pass    = sb_q.pass;

    // R4: the count only ever steps by one
    p_err_step_r4: assert property (@(posedge clk) disable iff (rst)
        (sb_q.err != $past(sb_q.err)) |-> (sb_q.err == ERR_W'($past(sb_q.err) + 1'b1)));

    // R5: once a window has been judged, it adds nothing more
    p_once_per_window_r5: assert property (@(posedge clk) disable iff (rst)
        (sb_q.done && req) |=> $stable(sb_q.err));

    // R7: write windows never touch the count
    p_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (req && !rd_sel) |=> $stable(sb_q.err));

    // R8: saturated count stays saturated
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (sb_q.err == ERR_MAX) |=> (sb_q.err == ERR_MAX));

    // R9: fail is sticky, pass never coexists with errors
    p_fail_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        sb_q.fail |=> sb_q.fail);

    p_pass_clean_r9: assert property (@(posedge clk) disable iff (rst)
        sb_q.pass |-> ((sb_q.err == '0) && !sb_q.fail));

endmodule

// File: rtl/mem_exerciser.sv
module mem_exerciser #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ERR_W   = 8,
    parameter int unsigned PH_W    = 8,
    parameter int unsigned IDX_W   = 2,
    parameter int unsigned REQ_ON  = 20,
    parameter int unsigned REQ_OFF = 118
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_wr_o,
    output logic              mem_req_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ready_i,
    output logic [ERR_W-1:0]  err_cnt_o,
    output logic              fail_o,
    output logic              pass_o
);
    logic             rd_sel, req, win_close, period_end;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] expect_word;

    mx_timebase #(
        .PH_W(PH_W), .IDX_W(IDX_W), .REQ_ON(REQ_ON), .REQ_OFF(REQ_OFF)
    ) u_timebase (
        .clk(clk), .rst(rst), .rd_sel(rd_sel), .idx(idx), .req(req),
        .win_close(win_close), .period_end(period_end)
    );

    mx_pattern #(
        .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_pattern (
        .idx(idx), .addr(mem_addr_o), .wdata(mem_wdata_o), .expect_word(expect_word)
    );

    mx_scoreboard #(
        .DATA_W(DATA_W), .ERR_W(ERR_W)
    ) u_scoreboard (
        .clk(clk), .rst(rst), .req(req), .rd_sel(rd_sel), .win_close(win_close),
        .period_end(period_end), .ready(mem_ready_i), .rdata(mem_rdata_i),
        .expect_word(expect_word), .err_cnt(err_cnt_o), .fail(fail_o), .pass(pass_o)
    );

    assign mem_req_o = req;
    assign mem_wr_o  = !rd_sel;

    // R10: nothing is requested in the cycle after reset
    p_reset_quiet_r10: assert property (@(posedge clk)
        $past(rst) |-> (!mem_req_o && (err_cnt_o == '0) && !fail_o && !pass_o));

endmodule

// File: tb/mem_exerciser_bench.sv
`timescale 1ns/1ps
module mem_exerciser_bench;
    localparam int ERR_W = 4;
    localparam int ERR_MAX = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        mem_wr, mem_req, mem_ready = 1'b0;
    logic [ERR_W-1:0] err_cnt;
    logic        fail, pass;

    int tests = 0;
    int fails = 0;

    // responder settings
    int          lat = 5;
    logic [31:0] cor_addr = '0;
    bit          cor_all = 1'b0;
    bit          garbage = 1'b0;
    int          rcnt = 0;
    logic [31:0] mem [256];

    always #2.5 clk = ~clk;

    mem_exerciser #(.ERR_W(ERR_W)) u_mem_exerciser (
        .clk(clk), .rst(rst), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_wr_o(mem_wr), .mem_req_o(mem_req), .mem_rdata_i(mem_rdata),
        .mem_ready_i(mem_ready), .err_cnt_o(err_cnt), .fail_o(fail), .pass_o(pass)
    );

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
    end

    // memory port model: latched ready after lat request cycles
    always @(posedge clk) begin
        if (rst || !mem_req) begin
            rcnt      <= 0;
            mem_ready <= 1'b0;
        end else begin
            rcnt <= rcnt + 1;
            if (!mem_ready && (rcnt + 1 == lat)) begin
                mem_ready <= 1'b1;
                if (mem_wr)
                    mem[mem_addr[7:0]] <= mem_wdata;
                else
                    mem_rdata <= mem[mem_addr[7:0]] ^
                                 ((cor_all || mem_addr == cor_addr) ? 32'h1 : 32'h0);
            end else if (mem_ready && garbage && !mem_wr) begin
                mem_rdata <= ~mem[mem_addr[7:0]];
            end
        end
    end

    function automatic logic [31:0] word_of(input int i);
        case (i)
            0: return 32'd20;
            1: return 32'd120;
            2: return 32'd30;
            3: return 32'd10;
            default: return 32'd111;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    int exp_err = 0;

    // one full counter period; entered at a falling edge with counter = 0
    task automatic run_period(input int l, input logic [31:0] ca, input bit call,
                              input bit garb, input int add_err, input string tag);
        lat = l; cor_addr = ca; cor_all = call; garbage = garb;
        for (int j = 0; j < 2048; j++) begin
            int ph  = j % 256;
            int ix  = (j / 256) % 4;
            bit rd  = (j / 1024) != 0;
            bit rq  = (ph >= 21) && (ph <= 118);
            chk(mem_req === rq, "R2 request window", mem_req, rq);
            chk(mem_wr === !rd, "R1 direction", mem_wr, !rd);
            chk(mem_addr === word_of(ix), "R3 address", mem_addr, word_of(ix));
            chk(mem_wdata === word_of(ix), "R3 write data", mem_wdata, word_of(ix));
            @(posedge clk); @(negedge clk);
        end
        exp_err = (exp_err + add_err > ERR_MAX) ? ERR_MAX : exp_err + add_err;
        chk(err_cnt == ERR_W'(exp_err), {tag, " error count"}, err_cnt, exp_err);
        chk(fail === (exp_err != 0), "R9 fail flag", fail, exp_err != 0);
        chk(pass === (exp_err == 0), "R9 pass flag", pass, exp_err == 0);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(mem_req === 1'b0, "R10 request after reset", mem_req, 0);
        chk(err_cnt == '0, "R10 error count after reset", err_cnt, 0);
        chk(fail === 1'b0, "R10 fail after reset", fail, 0);
        chk(pass === 1'b0, "R10 pass after reset", pass, 0);
        chk(mem_wr === 1'b1, "R1 first slot is a write", mem_wr, 1);
        rst = 1'b0;

        run_period(5,   32'd0,  1'b0, 1'b1, 0, "R4 R5 clean with late garbage");
        run_period(97,  32'd0,  1'b0, 1'b0, 0, "R6 ready on closing cycle");
        run_period(5,   32'd30, 1'b0, 1'b0, 1, "R4 corrupt entry 2");
        run_period(98,  32'd0,  1'b0, 1'b0, 4, "R6 ready one cycle too late");
        run_period(200, 32'd0,  1'b0, 1'b0, 4, "R6 R7 no ready at all");
        run_period(5,   32'd0,  1'b1, 1'b0, 4, "R4 every read corrupt");
        run_period(200, 32'd0,  1'b0, 1'b0, 4, "R8 saturation");
        run_period(5,   32'd20, 1'b0, 1'b0, 1, "R8 stays saturated");

        // R10: reset mid-run clears everything
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        exp_err = 0;
        chk(err_cnt == '0, "R10 error count after second reset", err_cnt, 0);
        chk(fail === 1'b0, "R10 fail after second reset", fail, 0);
        run_period(5, 32'd0, 1'b0, 1'b0, 0, "R1 R9 clean after reset");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule